// File: doc/BRIEF.md
# PWM Channel Status and Interrupt Flag Register

This block holds the 8-bit status word for one channel of a multi-channel PWM controller. Hardware events set sticky flags. Software clears a flag by writing a one to its bit position. The events are:

- a level change on either of the channel's two PWM outputs;
- a loss of lockstep between this channel's end of cycle and its master channel's end of cycle, checked while auto-run is on;
- a strobe from either of the two external retrigger/fault event sources;
- this channel's own end-of-cycle strobe.

When either external event fires, the register also latches the ramp index that was active at that moment. That index can be read but not written.

The master of a channel is the channel numbered one below it. Channel 0 takes the highest-numbered channel as its master, so the chain wraps around. The channel number and the channel count are parameters. The block receives the end-of-cycle strobes of all channels as one vector and picks out the two it needs.

A single interrupt line is the OR of the four event flags (sync error, event B, event A, end of cycle). Each of these is gated by its own bit of an 8-bit enable input. The two activity flags never raise the interrupt.

Top module: `pwm_flag_reg`

## Requirements
- R1: Bit 7 becomes 1 one clock after PWM output B is sampled at a level different from the level it had on the clock before. This applies to both rising and falling changes.
- R2: Bit 6 becomes 1 one clock after PWM output A is sampled at a level different from the level it had on the clock before. This applies to both rising and falling changes.
- R3: While auto-run is 1, bit 5 becomes 1 one clock after a clock in which exactly one of this channel's end-of-cycle strobe and the master's end-of-cycle strobe is high. While auto-run is 0, bit 5 is never set.
- R4: The master is channel CHAN_IDX-1. For channel 0 the master is channel NUM_CHAN-1. The strobes of other channels have no effect on bit 5.
- R5: An event A strobe sets bit 3 and an event B strobe sets bit 4, one clock later. This happens whatever the enable input holds.
- R6: Bits 2:1 take the value of the ramp index sampled in the clock of the most recent event A or event B strobe. The value 0 means ramp 1. These bits keep their value when there is no event, and register writes do not change them.
- R7: A write sets to 0 each of bits 7, 6, 5, 4, 3 and 0 whose write-data bit is 1. Bits whose write-data bit is 0 keep their value.
- R8: When a hardware set and a write-1 clear reach the same flag in the same clock, the flag ends up 1.
- R9: Bit 0 becomes 1 one clock after this channel's end-of-cycle strobe.
- R10: The interrupt output is 1 exactly when one of bits 5, 4, 3 or 0 is 1 and its matching enable bit is also 1. Bits 7 and 6 never drive the interrupt.
- R11: After reset every register bit reads 0 and the interrupt output is 0.
- R12: When event A and event B strobe in the same clock, both bits 4 and 3 are set and bits 2:1 take the ramp index of that clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| pwm_out_a | input | 1 | PWM output A of this channel |
| pwm_out_b | input | 1 | PWM output B of this channel |
| eoc_vec | input | NUM_CHAN | End-of-cycle strobes of all channels, one bit per channel |
| auto_run | input | 1 | Enables the master lockstep check |
| evt_a | input | 1 | External event strobe from retrigger/fault source A |
| evt_b | input | 1 | External event strobe from retrigger/fault source B |
| ramp_idx | input | 2 | Index of the ramp that is running now |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data; a 1 clears the matching flag |
| irq_en | input | 8 | Interrupt enable, one bit per register bit |
| rd_data | output | 8 | Current register contents |
| irq | output | 1 | Interrupt request |

## Verification
The checker's toggle properties assume that both PWM outputs are held low while reset is asserted. The toggle detectors start from a low reference level, and a high input at release would look like an edge the properties cannot explain. The properties are disabled until the internal synchronised reset has been released. They also take every strobe to be a single-clock pulse sampled at the clock edge. The bench drives all inputs low through reset and waits out the release delay. It then changes inputs only just after rising edges and holds each strobe for exactly one clock.

// File: rtl/pwm_flag_pkg.sv
package pwm_flag_pkg;
  localparam int REG_W       = 8;
  localparam int RAMP_W      = 2;
  localparam int BIT_ACT_B   = 7;
  localparam int BIT_ACT_A   = 6;
  localparam int BIT_SYNC    = 5;
  localparam int BIT_EVT_B   = 4;
  localparam int BIT_EVT_A   = 3;
  localparam int BIT_RAMP_LO = 1;
  localparam int BIT_EOC     = 0;
  // bits cleared by write-one
  localparam logic [REG_W-1:0] STICKY_MASK = 8'b1111_1001;
  // bits that may request an interrupt
  localparam logic [REG_W-1:0] IRQ_MASK    = 8'b0011_1001;
endpackage

// File: rtl/pwm_flag_rstsync.sv
module pwm_flag_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end

  assign rst_sync_n = stage_q[STAGES-1];
endmodule

// File: rtl/pwm_flag_edge.sv
module pwm_flag_edge #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] sig,
  output logic [N-1:0] toggled
);
  for (genvar i = 0; i < N; i++) begin : g_det
    logic prev_q;
    logic prev_d;

    always_comb begin
      prev_d = sig[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= prev_d;
    end

    assign toggled[i] = sig[i] ^ prev_q;
  end
endmodule

// File: rtl/pwm_flag_sync.sv
module pwm_flag_sync #(
  parameter int NUM_CHAN = 3,
  parameter int CHAN_IDX = 0
) (
  input  logic [NUM_CHAN-1:0] eoc_vec,
  input  logic                auto_run,
  output logic                eoc_self,
  output logic                sync_err
);
  localparam int MASTER_IDX = (CHAN_IDX == 0) ? NUM_CHAN - 1 : CHAN_IDX - 1;

  logic eoc_master;

  always_comb begin
    eoc_self   = eoc_vec[CHAN_IDX];
    eoc_master = eoc_vec[MASTER_IDX];
    sync_err   = auto_run & (eoc_self ^ eoc_master);
  end
endmodule

// File: rtl/pwm_flag_sticky.sv
module pwm_flag_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q
);
  logic q_d;

  // set has priority over a clear in the same clock
  always_comb begin
    q_d = set_i | (q & ~clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= q_d;
  end
endmodule

// File: rtl/pwm_flag_reg.sv
module pwm_flag_reg
  import pwm_flag_pkg::*;
#(
  parameter int NUM_CHAN = 3,
  parameter int CHAN_IDX = 0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pwm_out_a,
  input  logic                pwm_out_b,
  input  logic [NUM_CHAN-1:0] eoc_vec,
  input  logic                auto_run,
  input  logic                evt_a,
  input  logic                evt_b,
  input  logic [1:0]          ramp_idx,
  input  logic                wr_en,
  input  logic [7:0]          wr_data,
  input  logic [7:0]          irq_en,
  output logic [7:0]          rd_data,
  output logic                irq
);
  logic             rst_sync_n;
  logic [1:0]       toggled;
  logic             eoc_self;
  logic             sync_err;
  logic [REG_W-1:0] set_vec;
  logic [REG_W-1:0] clr_vec;
  logic [REG_W-1:0] flags;
  logic [RAMP_W-1:0] ramp_q;
  logic [RAMP_W-1:0] ramp_d;
  logic             ramp_cap;

  pwm_flag_rstsync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pwm_flag_edge #(.N(2)) u_edge (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .sig     ({pwm_out_b, pwm_out_a}),
    .toggled (toggled)
  );

  pwm_flag_sync #(.NUM_CHAN(NUM_CHAN), .CHAN_IDX(CHAN_IDX)) u_sync (
    .eoc_vec  (eoc_vec),
    .auto_run (auto_run),
    .eoc_self (eoc_self),
    .sync_err (sync_err)
  );

  always_comb begin
    set_vec              = '0;
    set_vec[BIT_ACT_B]   = toggled[1];
    set_vec[BIT_ACT_A]   = toggled[0];
    set_vec[BIT_SYNC]    = sync_err;
    set_vec[BIT_EVT_B]   = evt_b;
    set_vec[BIT_EVT_A]   = evt_a;
    set_vec[BIT_EOC]     = eoc_self;
    clr_vec              = wr_en ? (wr_data & STICKY_MASK) : '0;
  end

  for (genvar i = 0; i < REG_W; i++) begin : g_bit
    if (STICKY_MASK[i]) begin : g_sticky
      pwm_flag_sticky u_flag (
        .clk   (clk),
        .rst_n (rst_sync_n),
        .set_i (set_vec[i]),
        .clr_i (clr_vec[i]),
        .q     (flags[i])
      );
    end else begin : g_ramp
      assign flags[i] = ramp_q[i - BIT_RAMP_LO];
    end
  end

  // ramp index latch, one capture even if both events fire
  always_comb begin
    ramp_cap = evt_a | evt_b;
    ramp_d   = ramp_cap ? ramp_idx : ramp_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) ramp_q <= '0;
    else             ramp_q <= ramp_d;
  end

  assign rd_data = flags;
  assign irq     = |(flags & irq_en & IRQ_MASK);
endmodule

// File: rtl/pwm_flag_reg_chk.sv
module pwm_flag_reg_chk #(
  parameter int NUM_CHAN = 3,
  parameter int CHAN_IDX = 0
) (
  input logic                clk,
  input logic                rst_ok,
  input logic                pwm_out_a,
  input logic                pwm_out_b,
  input logic [NUM_CHAN-1:0] eoc_vec,
  input logic                auto_run,
  input logic                evt_a,
  input logic                evt_b,
  input logic [1:0]          ramp_idx,
  input logic                wr_en,
  input logic [7:0]          wr_data,
  input logic [7:0]          irq_en,
  input logic [7:0]          rd_data,
  input logic                irq
);
  localparam int MIDX = (CHAN_IDX == 0) ? NUM_CHAN - 1 : CHAN_IDX - 1;

  AST_ACT_B_SET: assert property (@(posedge clk) disable iff (!rst_ok)
    (pwm_out_b != $past(pwm_out_b)) |=> rd_data[7]); // R1
  AST_ACT_A_SET: assert property (@(posedge clk) disable iff (!rst_ok)
    (pwm_out_a != $past(pwm_out_a)) |=> rd_data[6]); // R2
  AST_SYNC_SET: assert property (@(posedge clk) disable iff (!rst_ok)
    (auto_run && (eoc_vec[CHAN_IDX] != eoc_vec[MIDX])) |=> rd_data[5]); // R4
  AST_SYNC_QUIET: assert property (@(posedge clk) disable iff (!rst_ok)
    (!auto_run && !rd_data[5]) |=> !rd_data[5]); // R3
  AST_EVT_A_SET: assert property (@(posedge clk) disable iff (!rst_ok)
    evt_a |=> rd_data[3]); // R5
  AST_EVT_B_SET: assert property (@(posedge clk) disable iff (!rst_ok)
    evt_b |=> rd_data[4]); // R5
  AST_RAMP_CAPTURE: assert property (@(posedge clk) disable iff (!rst_ok)
    (evt_a || evt_b) |=> (rd_data[2:1] == $past(ramp_idx))); // R12
  AST_RAMP_HOLD: assert property (@(posedge clk) disable iff (!rst_ok)
    !(evt_a || evt_b) |=> $stable(rd_data[2:1])); // R6
  AST_EVT_A_CLEAR: assert property (@(posedge clk) disable iff (!rst_ok)
    (wr_en && wr_data[3] && !evt_a) |=> !rd_data[3]); // R7
  AST_EVT_A_STICKY: assert property (@(posedge clk) disable iff (!rst_ok)
    (rd_data[3] && !(wr_en && wr_data[3])) |=> rd_data[3]); // R7
  AST_EOC_SET: assert property (@(posedge clk) disable iff (!rst_ok)
    eoc_vec[CHAN_IDX] |=> rd_data[0]); // R9
  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_ok)
    irq |-> ((rd_data & irq_en & 8'h39) != 8'h00)); // R10
  AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_ok)
    ((rd_data & irq_en & 8'h39) != 8'h00) |-> irq); // R10
endmodule

bind pwm_flag_reg pwm_flag_reg_chk #(.NUM_CHAN(NUM_CHAN), .CHAN_IDX(CHAN_IDX)) u_chk (
  .clk       (clk),
  .rst_ok    (rst_sync_n),
  .pwm_out_a (pwm_out_a),
  .pwm_out_b (pwm_out_b),
  .eoc_vec   (eoc_vec),
  .auto_run  (auto_run),
  .evt_a     (evt_a),
  .evt_b     (evt_b),
  .ramp_idx  (ramp_idx),
  .wr_en     (wr_en),
  .wr_data   (wr_data),
  .irq_en    (irq_en),
  .rd_data   (rd_data),
  .irq       (irq)
);

// File: tb/pwm_flag_reg_tb.sv
module pwm_flag_reg_tb;
  localparam int NC = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          pwm_out_a, pwm_out_b;
  logic [NC-1:0] eoc_vec;
  logic          auto_run, evt_a, evt_b;
  logic [1:0]    ramp_idx;
  logic          wr_en;
  logic [7:0]    wr_data, irq_en, rd_data;
  logic          irq;
  int            n_chk = 0;
  int            n_fail = 0;
  bit            done = 0;

  always #2.5 clk = ~clk;

  pwm_flag_reg #(.NUM_CHAN(NC), .CHAN_IDX(0)) u_dut (
    .clk(clk), .rst_n(rst_n), .pwm_out_a(pwm_out_a), .pwm_out_b(pwm_out_b),
    .eoc_vec(eoc_vec), .auto_run(auto_run), .evt_a(evt_a), .evt_b(evt_b),
    .ramp_idx(ramp_idx), .wr_en(wr_en), .wr_data(wr_data), .irq_en(irq_en),
    .rd_data(rd_data), .irq(irq)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_all();
    wr_en = 1'b1; wr_data = 8'hFF; tick();
    wr_en = 1'b0; wr_data = 8'h00;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; pwm_out_a = 0; pwm_out_b = 0; eoc_vec = '0; auto_run = 0;
    evt_a = 0; evt_b = 0; ramp_idx = 2'd0; wr_en = 0; wr_data = 0; irq_en = 8'hFF;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (3) tick();
    chk("R11 reg", rd_data, 8'h00);
    chk("R11 irq", {7'd0, irq}, 8'h00);
    irq_en = 8'h00;
  endtask

  task automatic t_toggle();
    pwm_out_a = 1; tick(); pwm_out_a = 1;
    chk("R2 rise", rd_data & 8'hC0, 8'h40);
    clear_all(); tick();
    chk("R2 steady high", rd_data & 8'hC0, 8'h00);
    pwm_out_a = 0; tick();
    chk("R2 fall", rd_data & 8'hC0, 8'h40);
    clear_all();
    pwm_out_b = 1; tick();
    chk("R1 rise", rd_data & 8'hC0, 8'h80);
    clear_all();
    pwm_out_b = 0; tick();
    chk("R1 fall", rd_data & 8'hC0, 8'h80);
    clear_all();
  endtask

  task automatic t_sync();
    auto_run = 1; eoc_vec = 3'b001; tick(); eoc_vec = '0;
    chk("R3 self alone", rd_data & 8'h21, 8'h21);
    clear_all();
    eoc_vec = 3'b101; tick(); eoc_vec = '0;
    chk("R3 lockstep", rd_data & 8'h21, 8'h01);
    clear_all();
    eoc_vec = 3'b100; tick(); eoc_vec = '0;
    chk("R4 wrap master alone", rd_data & 8'h21, 8'h20);
    clear_all();
    eoc_vec = 3'b011; tick(); eoc_vec = '0;
    chk("R4 non-master ignored", rd_data & 8'h21, 8'h21);
    clear_all();
    eoc_vec = 3'b010; tick(); eoc_vec = '0;
    chk("R4 non-master alone", rd_data, 8'h00);
    auto_run = 0; eoc_vec = 3'b001; tick(); eoc_vec = '0;
    chk("R3 auto-run off", rd_data & 8'h21, 8'h01);
    chk("R9 eoc", rd_data & 8'h01, 8'h01);
    clear_all();
  endtask

  task automatic t_events();
    irq_en = 8'h00;
    ramp_idx = 2'd2; evt_a = 1; tick(); evt_a = 0; ramp_idx = 2'd3;
    chk("R5 evt A no enable", rd_data, 8'h0C);
    chk("R10 masked", {7'd0, irq}, 8'h00);
    tick();
    chk("R6 ramp hold", rd_data & 8'h06, 8'h04);
    wr_en = 1; wr_data = 8'hFF; tick(); wr_en = 0; wr_data = 0;
    chk("R6 write ignored", rd_data, 8'h04);
    evt_b = 1; tick(); evt_b = 0;
    chk("R5 evt B", rd_data, 8'h16);
    wr_en = 1; wr_data = 8'h08; tick(); wr_en = 0; wr_data = 0;
    chk("R7 clear other bit", rd_data, 8'h16);
    wr_en = 1; wr_data = 8'h10; tick(); wr_en = 0; wr_data = 0;
    chk("R7 clear one", rd_data, 8'h06);
    ramp_idx = 2'd1; evt_a = 1; evt_b = 1; tick(); evt_a = 0; evt_b = 0;
    chk("R12 both events", rd_data, 8'h1A);
    wr_en = 1; wr_data = 8'h00; tick(); wr_en = 0;
    chk("R7 write zero", rd_data, 8'h1A);
    ramp_idx = 2'd0; evt_b = 1; tick(); evt_b = 0;
    chk("R6 ramp 1 code", rd_data & 8'h06, 8'h00);
    clear_all();
  endtask

  task automatic t_race();
    evt_a = 1; wr_en = 1; wr_data = 8'h08; tick(); evt_a = 0; wr_en = 0; wr_data = 0;
    chk("R8 event vs clear", rd_data & 8'h08, 8'h08);
    pwm_out_a = 1; wr_en = 1; wr_data = 8'h40; tick(); wr_en = 0; wr_data = 0;
    chk("R8 toggle vs clear", rd_data & 8'h40, 8'h40);
    clear_all();
    pwm_out_a = 0; tick(); clear_all();
  endtask

  task automatic t_irq();
    pwm_out_a = 1; pwm_out_b = 1; tick();
    irq_en = 8'hC0; #1;
    chk("R10 activity no irq", {7'd0, irq}, 8'h00);
    evt_a = 1; tick(); evt_a = 0;
    irq_en = 8'h10; #1;
    chk("R10 wrong enable", {7'd0, irq}, 8'h00);
    irq_en = 8'h08; #1;
    chk("R10 evt A enabled", {7'd0, irq}, 8'h01);
    clear_all();
    chk("R10 after clear", {7'd0, irq}, 8'h00);
    eoc_vec = 3'b001; tick(); eoc_vec = '0;
    irq_en = 8'h01; #1;
    chk("R10 eoc enabled", {7'd0, irq}, 8'h01);
    auto_run = 1; eoc_vec = 3'b100; tick(); eoc_vec = '0; auto_run = 0;
    irq_en = 8'h20; #1;
    chk("R10 sync enabled", {7'd0, irq}, 8'h01);
    irq_en = 8'h00; clear_all();
  endtask

  initial begin
    t_reset();
    t_toggle();
    t_sync();
    t_events();
    t_race();
    t_irq();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule